// File: doc/BRIEF.md
# Microprogram Sequencer with Writable Control Store

This block is the control core of a microprogrammed processor. It keeps a 7-bit control address register and a one-entry subroutine return register, and it holds a 128-word by 20-bit writable control memory. Each cycle the word at the current control address is presented. Its three micro-operation fields go to the datapath. Its condition, branch and address fields pick the next control address. The next address is one of four: the current address plus one, the word's address field, the saved return address, or an instruction start address built from the 4-bit machine opcode.

Microcode is loaded through a simple write port, and only while reset is held. When reset is released, execution starts at the fetch routine at address 64. Instruction routines begin on four-word boundaries in the lower half of the store. The opcode mapping turns opcode k into address 4k. Unused words are normally loaded with a jump back to 64, so that a stray control address leads back into the fetch routine.

Top module: `microSequencer`

## Requirements
- R1: While reset is high, the control address is forced to 64. After reset is released, the micro-operation outputs show the fields of word 64 until the first active clock edge.
- R2: Word layout: bits [19:17], [16:14] and [13:11] are micro-operation fields 1, 2 and 3. They appear on microOps[8:6], [5:3] and [2:0]. Bits [10:9] are the condition select, [8:7] are the branch type and [6:0] are the address field. The outputs always show the word at the current control address.
- R3: Condition select 00 is always true, 01 tests indBit, 10 tests acSign and 11 tests acZero. When the condition is false, JMP (branch 00) and CALL (branch 01) advance the control address by one and leave the return register unchanged.
- R4: For JMP with a true condition, the next control address is the address field.
- R5: For CALL with a true condition, the next control address is the address field, and the current address plus one is stored in the return register.
- R6: RET (branch 10) loads the control address from the return register, whatever the condition and the address field.
- R7: MAP (branch 11) loads the control address with {0, opCode[3:0], 0, 0}, whatever the condition and the address field.
- R8: A write with wrEn high while rst is high stores wrData at wrAddr. The stored word is used once execution reaches that address.
- R9: A write attempted while rst is low does not change the control memory.
- R10: Advancing by one from address 127 wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset; also enables microcode writes |
| opCode | input | 4 | Machine instruction opcode used by MAP |
| indBit | input | 1 | Indirect addressing bit of the instruction |
| acSign | input | 1 | Accumulator sign flag |
| acZero | input | 1 | Accumulator-is-zero flag |
| wrEn | input | 1 | Control memory write strobe (effective only in reset) |
| wrAddr | input | 7 | Control memory write address |
| wrData | input | 20 | Microinstruction word to store |
| microOps | output | 9 | Three 3-bit micro-operation fields of the current word |

## Verification
The hardest situations to reach from the ports are a write that arrives while the sequencer runs, and the wrap from address 127 to 0. A blocked write only shows up once control later lands on the targeted word. A wrap needs a chain of taken and untaken conditions that leads into the top of the store. The bench loads a microprogram in which every word's micro-operation fields encode the word's own address, so the outputs identify the control address in every cycle. It fires a write at address 100 during a long pseudo-random run. It then re-enters reset without writing and drives the exact flag sequence that routes 80 to 100, and later 84 to 127 to 0. The same directed phase steps through a call into the shared subroutine and its return, which carries a nonzero address field and a false condition.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

  typedef enum logic [1:0] {
    CD_ALWAYS = 2'b00,
    CD_IND    = 2'b01,
    CD_SIGN   = 2'b10,
    CD_ZERO   = 2'b11
  } condSel_e;

  typedef enum logic [1:0] {
    BR_JMP  = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } branchKind_e;

  // Strobes from the sequencing control to the address datapath
  typedef struct packed {
    logic selAd;    // take address field
    logic selRet;   // take saved return address
    logic selMap;   // take opcode-mapped address
    logic saveRet;  // store current address + 1 as return address
  } seqStrobes_t;

endpackage

// File: rtl/ucodeStore.sv
`timescale 1ns/1ps
module ucodeStore #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] memArray [DEPTH];

  // Synchronous read; address is the next control address so the
  // registered output always matches the control address register.
  always_ff @(posedge clk) begin
    if (wrEn) memArray[wrAddr] <= wrData;
    rdData <= memArray[rdAddr];
  end
endmodule

// File: rtl/seqControl.sv
`timescale 1ns/1ps
module seqControl
  import useq_pkg::*;
(
  input  condSel_e    condSel,
  input  branchKind_e branchKind,
  input  logic        indBit,
  input  logic        acSign,
  input  logic        acZero,
  output seqStrobes_t strobes
);
  logic condTrue;

  always_comb begin
    unique case (condSel)
      CD_ALWAYS: condTrue = 1'b1;
      CD_IND:    condTrue = indBit;
      CD_SIGN:   condTrue = acSign;
      CD_ZERO:   condTrue = acZero;
      default:   condTrue = 1'b1;
    endcase
  end

  always_comb begin
    strobes = '0;
    unique case (branchKind)
      BR_JMP:  strobes.selAd = condTrue;
      BR_CALL: begin
        strobes.selAd   = condTrue;
        strobes.saveRet = condTrue;
      end
      BR_RET:  strobes.selRet = 1'b1;
      BR_MAP:  strobes.selMap = 1'b1;
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/seqDatapath.sv
`timescale 1ns/1ps
module seqDatapath
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int FETCH_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] adField,
  input  logic [OPC_W-1:0]  opCode,
  output logic [ADDR_W-1:0] car,
  output logic [ADDR_W-1:0] sbr,
  output logic [ADDR_W-1:0] carNext
);
  localparam int SLOT_W = 2;
  localparam int PAD_W  = ADDR_W - OPC_W - SLOT_W;
  localparam logic [ADDR_W-1:0] FETCH_VEC = ADDR_W'(FETCH_ADDR);

  logic [ADDR_W-1:0] carInc;
  logic [ADDR_W-1:0] mapAddr;

  generate
    if (PAD_W > 0) begin : g_mapPad
      assign mapAddr = {{PAD_W{1'b0}}, opCode, {SLOT_W{1'b0}}};
    end else begin : g_mapNoPad
      assign mapAddr = ADDR_W'({opCode, {SLOT_W{1'b0}}});
    end
  endgenerate

  assign carInc = car + ADDR_W'(1);

  always_comb begin
    if (rst)                 carNext = FETCH_VEC;
    else if (strobes.selMap) carNext = mapAddr;
    else if (strobes.selRet) carNext = sbr;
    else if (strobes.selAd)  carNext = adField;
    else                     carNext = carInc;
  end

  always_ff @(posedge clk) begin
    car <= carNext;
    if (rst)                  sbr <= '0;
    else if (strobes.saveRet) sbr <= carInc;
  end
endmodule

// File: rtl/microSequencer.sv
`timescale 1ns/1ps
module microSequencer
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int MOP_W      = 3,
  parameter int MOP_N      = 3,
  parameter int FETCH_ADDR = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [OPC_W-1:0]         opCode,
  input  logic                     indBit,
  input  logic                     acSign,
  input  logic                     acZero,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [MOP_N*MOP_W+4+ADDR_W-1:0] wrData,
  output logic [MOP_N*MOP_W-1:0]   microOps
);
  localparam int OPS_W  = MOP_N * MOP_W;
  localparam int WORD_W = OPS_W + 4 + ADDR_W;
  localparam int CD_LSB = ADDR_W + 2;
  localparam int BR_LSB = ADDR_W;

  logic [WORD_W-1:0] uWord;
  logic [ADDR_W-1:0] car;
  logic [ADDR_W-1:0] sbr;
  logic [ADDR_W-1:0] carNext;
  seqStrobes_t       strobes;
  logic              storeWrite;

  // Microcode may only change while the sequencer is held in reset
  assign storeWrite = wrEn & rst;

  ucodeStore #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk    (clk),
    .wrEn   (storeWrite),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (carNext),
    .rdData (uWord)
  );

  seqControl u_ctrl (
    .condSel    (condSel_e'(uWord[CD_LSB +: 2])),
    .branchKind (branchKind_e'(uWord[BR_LSB +: 2])),
    .indBit     (indBit),
    .acSign     (acSign),
    .acZero     (acZero),
    .strobes    (strobes)
  );

  seqDatapath #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .FETCH_ADDR(FETCH_ADDR)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .adField (uWord[ADDR_W-1:0]),
    .opCode  (opCode),
    .car     (car),
    .sbr     (sbr),
    .carNext (carNext)
  );

  assign microOps = uWord[WORD_W-1 -: OPS_W];
endmodule

// File: rtl/microSequencer_chk.sv
`timescale 1ns/1ps
module microSequencerChecker #(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int WORD_W     = 20,
  parameter int FETCH_ADDR = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [OPC_W-1:0]  opCode,
  input logic              indBit,
  input logic              acSign,
  input logic              acZero,
  input logic [ADDR_W-1:0] car,
  input logic [ADDR_W-1:0] sbr,
  input logic [WORD_W-1:0] uWord
);
  logic [1:0]        cd;
  logic [1:0]        br;
  logic [ADDR_W-1:0] ad;
  logic              cond;

  assign cd = uWord[ADDR_W+3:ADDR_W+2];
  assign br = uWord[ADDR_W+1:ADDR_W];
  assign ad = uWord[ADDR_W-1:0];
  assign cond = (cd == 2'b00) | ((cd == 2'b01) & indBit) |
                ((cd == 2'b10) & acSign) | ((cd == 2'b11) & acZero);

  // R1
  a_r1_fetch_entry: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> car == ADDR_W'(FETCH_ADDR));

  // R3
  a_r3_cond_false_step: assert property (@(posedge clk) disable iff (rst)
    ((br == 2'b00 || br == 2'b01) && !cond) |=>
      (car == $past(car) + ADDR_W'(1)) && $stable(sbr));

  // R4
  a_r4_jmp_taken: assert property (@(posedge clk) disable iff (rst)
    (br == 2'b00 && cond) |=> car == $past(ad));

  // R5
  a_r5_call_taken: assert property (@(posedge clk) disable iff (rst)
    (br == 2'b01 && cond) |=>
      (car == $past(ad)) && (sbr == $past(car) + ADDR_W'(1)));

  // R6
  a_r6_ret_restore: assert property (@(posedge clk) disable iff (rst)
    (br == 2'b10) |=> car == $past(sbr));

  // R7
  a_r7_map_opcode: assert property (@(posedge clk) disable iff (rst)
    (br == 2'b11) |=> car == ADDR_W'({$past(opCode), 2'b00}));
endmodule

bind microSequencer microSequencerChecker #(
  .ADDR_W(ADDR_W), .OPC_W(OPC_W), .WORD_W(WORD_W), .FETCH_ADDR(FETCH_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .opCode(opCode), .indBit(indBit), .acSign(acSign),
  .acZero(acZero), .car(car), .sbr(sbr), .uWord(uWord)
);

// File: tb/microSequencer_bench.sv
`timescale 1ns/1ps
module microSequencer_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opCode = '0;
  logic        indBit = 1'b0, acSign = 1'b0, acZero = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [19:0] wrData = '0;
  logic [8:0]  microOps;

  microSequencer u_microSequencer (
    .clk(clk), .rst(rst), .opCode(opCode), .indBit(indBit), .acSign(acSign),
    .acZero(acZero), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .microOps(microOps)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [19:0] mdl [128];
  logic [6:0]  mCar, mSbr;
  logic [8:0]  qMop [$];
  logic [6:0]  qAddr [$];
  string       qTag [$];

  // Word: {mop1,mop2,mop3 = {2'b00, own address}, cd, br, ad}
  function automatic logic [19:0] mkWord(int a, logic [1:0] cd, logic [1:0] br, int ad);
    return {2'b00, 7'(a), cd, br, 7'(ad)};
  endfunction

  task automatic check(string tag, logic [8:0] got, logic [8:0] exp, logic [6:0] addr);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at addr %0d: actual %h expected %h", tag, addr, got, exp);
    end
  endtask

  // Monitor: compares output shortly after each edge against the scoreboard
  always @(posedge clk) begin
    #1;
    if (qMop.size() > 0) begin
      logic [8:0] m; logic [6:0] a; string t;
      m = qMop.pop_front(); a = qAddr.pop_front(); t = qTag.pop_front();
      check(t, microOps, m, a);
    end
  end

  // Driver: called at a falling edge; predicts the next address and pushes it
  task automatic step(logic [3:0] op, logic i, logic s, logic z,
                      logic we = 1'b0, logic [6:0] wa = '0, logic [19:0] wd = '0);
    logic [19:0] w; logic c; logic [6:0] nxt; string tag;
    opCode = op; indBit = i; acSign = s; acZero = z;
    wrEn = we; wrAddr = wa; wrData = wd;
    w = mdl[mCar];
    case (w[10:9])
      2'b00: c = 1'b1;
      2'b01: c = i;
      2'b10: c = s;
      default: c = z;
    endcase
    case (w[8:7])
      2'b00: begin nxt = c ? w[6:0] : mCar + 7'd1; tag = c ? "R4" : "R3"; end
      2'b01: begin
        if (c) begin mSbr = mCar + 7'd1; nxt = w[6:0]; tag = "R5"; end
        else begin nxt = mCar + 7'd1; tag = "R3"; end
      end
      2'b10: begin nxt = mSbr; tag = "R6"; end
      default: begin nxt = {1'b0, op, 2'b00}; tag = "R7"; end
    endcase
    if (mCar == 7'd127 && nxt == 7'd0) tag = "R10";
    if (nxt == 7'd100) tag = "R9";
    qMop.push_back(mdl[nxt][19:11]);
    qAddr.push_back(nxt);
    qTag.push_back(tag);
    mCar = nxt;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset(bit load);
    rst = 1'b1;
    @(negedge clk);
    if (load) begin
      for (int a = 0; a < 128; a++) begin
        wrEn = 1'b1; wrAddr = 7'(a); wrData = mdl[a];
        @(negedge clk);
      end
      wrEn = 1'b0;
    end
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mCar = 7'd64; mSbr = 7'd0;
    // R1 R2 R8: word 64 (written in reset) is shown after reset release
    check("R1 R2 R8", microOps, mdl[64][19:11], 7'd64);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // Default fill: every word jumps back to fetch at 64
    for (int a = 0; a < 128; a++) mdl[a] = mkWord(a, 2'b00, 2'b00, 64);
    mdl[64] = mkWord(64, 2'b00, 2'b00, 65);
    mdl[65] = mkWord(65, 2'b01, 2'b11, 99);   // MAP; condition and AD ignored
    for (int k = 0; k < 16; k++) begin
      mdl[4*k]   = mkWord(4*k,   2'b01, 2'b01, 70);  // I CALL indirect
      mdl[4*k+1] = mkWord(4*k+1, 2'b10, 2'b00, 80);  // S JMP 80
      mdl[4*k+2] = mkWord(4*k+2, 2'b11, 2'b00, 84);  // Z JMP 84
      mdl[4*k+3] = mkWord(4*k+3, 2'b00, 2'b00, 64);
    end
    mdl[70]  = mkWord(70, 2'b00, 2'b00, 71);
    mdl[71]  = mkWord(71, 2'b11, 2'b10, 33);  // RET; Z condition and AD ignored
    mdl[80]  = mkWord(80, 2'b00, 2'b00, 100);
    mdl[84]  = mkWord(84, 2'b00, 2'b00, 127);
    mdl[127] = mkWord(127, 2'b01, 2'b00, 5);  // I JMP 5, else wraps to 0

    doReset(1'b1);

    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n == 50)  // R9: write attempt while running must be ignored
        step(lfsr[3:0], lfsr[4], lfsr[5], lfsr[6], 1'b1, 7'd100,
             {9'h1FF, 2'b00, 2'b00, 7'd0});
      else
        step(lfsr[3:0], lfsr[4], lfsr[5], lfsr[6]);
    end

    // Directed: re-enter reset without loading, then walk known paths
    doReset(1'b0);
    step(4'd0, 1'b0, 1'b1, 1'b0);  // 64 -> 65 (R4)
    step(4'd0, 1'b0, 1'b1, 1'b0);  // 65 MAP -> 0 (R7)
    step(4'd0, 1'b0, 1'b1, 1'b0);  // 0 CALL not taken -> 1 (R3)
    step(4'd0, 1'b0, 1'b1, 1'b0);  // 1 -> 80
    step(4'd0, 1'b0, 1'b1, 1'b0);  // 80 -> 100, unchanged word (R9)
    step(4'd0, 1'b0, 1'b1, 1'b0);  // 100 -> 64
    step(4'd3, 1'b1, 1'b0, 1'b0);  // 64 -> 65
    step(4'd3, 1'b1, 1'b0, 1'b0);  // 65 MAP -> 12 (R7)
    step(4'd3, 1'b1, 1'b0, 1'b0);  // 12 CALL -> 70 (R5)
    step(4'd3, 1'b1, 1'b0, 1'b0);  // 70 -> 71
    step(4'd3, 1'b1, 1'b0, 1'b0);  // 71 RET -> 13 (R6)
    step(4'd3, 1'b0, 1'b0, 1'b1);  // 13 S false -> 14 (R3)
    step(4'd3, 1'b0, 1'b0, 1'b1);  // 14 Z true -> 84 (R4)
    step(4'd3, 1'b0, 1'b0, 1'b1);  // 84 -> 127
    step(4'd3, 1'b0, 1'b0, 1'b1);  // 127 I false -> 0 (R10)
    step(4'd3, 1'b1, 1'b0, 1'b1);  // 0 CALL -> 70 (R5)

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule